// File: doc/BRIEF.md
# Port-Mapped Arithmetic/Logic Peripheral

This block is an 8-bit arithmetic and logic unit that a small processor reaches through four adjacent port addresses on its I/O bus. Software stores the first operand, then the second operand, then writes an operation code. The opcode write is the trigger. On that same clock edge the block computes the result and the condition flags and latches them. Software then reads the result port. The three flags (greater/carry, smaller, equal/zero) leave the block as plain outputs, so the core's conditional-execution logic can use them directly.

The flags hold their values from one operation to the next. ADD and SUB take the held carry as an input. SHL and SHR shift through it. A compare reports its outcome only through the flags and leaves the result register as it was. Reads outside the four ports are left unclaimed, so other devices on the same bus can answer them.

Top module: `alu_port_periph`

## Requirements
- R1: A synchronous active-high reset clears operand A, operand B, the stored opcode, the result and all three flags to zero.
- R2: With the default base 0xFFFC, a write to 0xFFFC stores A, a write to 0xFFFD stores B and a write to 0xFFFE stores the low four data bits as the opcode. A read returns A, B, the zero-extended opcode or the result at 0xFFFC, 0xFFFD, 0xFFFE and 0xFFFF, with the read-enable output high. A read of any other address keeps read-enable low, and a write to any other address changes nothing.
- R3: The result and the flags are updated only on the clock edge that samples an opcode write. They keep their values across operand writes and across reads.
- R4: ADD (opcode 0) gives A+B+gt modulo 256 and sets gt to the carry out. lt and eq are kept.
- R5: SUB (opcode 1) gives A−B−gt modulo 256 and sets gt to 1 exactly when A < B+gt. lt and eq are kept.
- R6: SHL (opcode 2) gives {A[6:0],gt} with the new gt equal to A[7]. SHR (opcode 3) gives {gt,A[7:1]} with the new gt equal to A[0]. lt and eq are kept.
- R7: ROL (opcode 4) gives {A[6:0],A[7]} and ROR (opcode 5) gives {A[0],A[7:1]}. All flags are kept.
- R8: OR (6), AND (7), NAND (8), XOR (9) and XNOR (10) give the bitwise function of A and B. All flags are kept.
- R9: CMP (opcode 11) sets gt=(A>B), lt=(A<B) and eq=(A==B), with A and B unsigned, and leaves the result register unchanged.
- R10: INC (opcode 12) gives A+1 and DEC (opcode 13) gives A−1, both modulo 256, and set eq exactly when the result is zero. gt and lt are kept.
- R11: Opcodes 14 and 15 are stored but leave the result and all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Port address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data |
| bus_rd_en | output | 1 | High when a read hits one of the four ports |
| flag_gt | output | 1 | Greater / carry flag |
| flag_lt | output | 1 | Smaller flag |
| flag_eq | output | 1 | Equal / zero flag |

## Verification
The bench builds the block with its default parameters: an 8-bit datapath, a 16-bit address and the base at 0xFFFC. These values put the carry edges (0xFF+0x01, 0x00−0x01) and the zero crossings of INC and DEC inside a short run. Because the flags carry over from one operation to the next, random sequences of operations test the use of the held carry. The four-port decode is tested against neighbouring addresses just below the base and far from it.

// File: rtl/alu_port_periph.sv
module alu_port_periph #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hFFFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rd_en,
  output logic          flag_gt,
  output logic          flag_lt,
  output logic          flag_eq
);
  localparam int OPW = 4;
  localparam logic [OPW-1:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_SHL = 4'd2,
    OP_SHR = 4'd3, OP_ROL = 4'd4, OP_ROR = 4'd5, OP_OR = 4'd6,
    OP_AND = 4'd7, OP_NAND = 4'd8, OP_XOR = 4'd9, OP_XNOR = 4'd10,
    OP_CMP = 4'd11, OP_INC = 4'd12, OP_DEC = 4'd13;

  logic [DW-1:0]  a_q, b_q, res_q, nres;
  logic [OPW-1:0] op_q, op_in;
  logic           gt_q, lt_q, eq_q, ngt, nlt, neq;
  logic [DW:0]    ext;

  wire       hit   = bus_addr[AW-1:2] == BASE[AW-1:2];
  wire [1:0] off   = bus_addr[1:0];
  wire       wr_a  = bus_wr && hit && off == 2'd0;
  wire       wr_b  = bus_wr && hit && off == 2'd1;
  wire       wr_op = bus_wr && hit && off == 2'd2;

  assign op_in = bus_wdata[OPW-1:0];

  always_comb begin
    nres = res_q;
    ngt  = gt_q;
    nlt  = lt_q;
    neq  = eq_q;
    ext  = '0;
    case (op_in)
      OP_ADD: begin
        ext  = {1'b0, a_q} + {1'b0, b_q} + (DW+1)'(gt_q);
        nres = ext[DW-1:0];
        ngt  = ext[DW];
      end
      OP_SUB: begin
        ext  = {1'b0, a_q} - {1'b0, b_q} - (DW+1)'(gt_q);
        nres = ext[DW-1:0];
        ngt  = ext[DW];
      end
      OP_SHL: begin
        nres = {a_q[DW-2:0], gt_q};
        ngt  = a_q[DW-1];
      end
      OP_SHR: begin
        nres = {gt_q, a_q[DW-1:1]};
        ngt  = a_q[0];
      end
      OP_ROL:  nres = {a_q[DW-2:0], a_q[DW-1]};
      OP_ROR:  nres = {a_q[0], a_q[DW-1:1]};
      OP_OR:   nres = a_q | b_q;
      OP_AND:  nres = a_q & b_q;
      OP_NAND: nres = ~(a_q & b_q);
      OP_XOR:  nres = a_q ^ b_q;
      OP_XNOR: nres = ~(a_q ^ b_q);
      OP_CMP: begin
        ngt = a_q > b_q;
        nlt = a_q < b_q;
        neq = a_q == b_q;
      end
      OP_INC: begin
        nres = a_q + DW'(1);
        neq  = nres == '0;
      end
      OP_DEC: begin
        nres = a_q - DW'(1);
        neq  = nres == '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      op_q  <= '0;
      res_q <= '0;
      gt_q  <= 1'b0;
      lt_q  <= 1'b0;
      eq_q  <= 1'b0;
    end else begin
      if (wr_a) a_q <= bus_wdata;
      if (wr_b) b_q <= bus_wdata;
      if (wr_op) begin
        op_q  <= op_in;
        res_q <= nres;
        gt_q  <= ngt;
        lt_q  <= nlt;
        eq_q  <= neq;
      end
    end
  end

  always_comb begin
    case (off)
      2'd0:    bus_rdata = a_q;
      2'd1:    bus_rdata = b_q;
      2'd2:    bus_rdata = {{(DW-OPW){1'b0}}, op_q};
      default: bus_rdata = res_q;
    endcase
  end

  assign bus_rd_en = bus_rd && hit;
  assign flag_gt   = gt_q;
  assign flag_lt   = lt_q;
  assign flag_eq   = eq_q;
endmodule

// File: rtl/alu_port_periph_chk.sv
module alu_port_periph_chk #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter logic [AW-1:0] BASE = 16'hFFFC
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_rd_en,
  input logic [DW-1:0] a_q,
  input logic [DW-1:0] res_q,
  input logic          flag_gt,
  input logic          flag_lt,
  input logic          flag_eq
);
  wire op_wr  = bus_wr && bus_addr == BASE + AW'(2);
  wire in_win = bus_addr >= BASE && bus_addr <= BASE + AW'(3);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> res_q == '0 && !flag_gt && !flag_lt && !flag_eq);

  // R2
  decode_window_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !in_win) |-> !bus_rd_en);

  // R3
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !op_wr |=> $stable(res_q) && $stable({flag_gt, flag_lt, flag_eq}));

  // R9
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    (op_wr && bus_wdata[3:0] == 4'd11) |=>
      $countones({flag_gt, flag_lt, flag_eq}) == 1 && $stable(res_q));

  // R10
  inc_value_chk: assert property (@(posedge clk) disable iff (rst)
    (op_wr && bus_wdata[3:0] == 4'd12) |=> res_q == DW'($past(a_q) + 1));

  // R11
  undefined_op_chk: assert property (@(posedge clk) disable iff (rst)
    (op_wr && bus_wdata[3:0] >= 4'd14) |=>
      $stable(res_q) && $stable({flag_gt, flag_lt, flag_eq}));
endmodule

bind alu_port_periph alu_port_periph_chk #(.DW(DW), .AW(AW), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rd_en(bus_rd_en), .a_q(a_q),
  .res_q(res_q), .flag_gt(flag_gt), .flag_lt(flag_lt), .flag_eq(flag_eq)
);

// File: tb/alu_port_periph_tb.sv
module alu_port_periph_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_rd_en;
  logic        flag_gt, flag_lt, flag_eq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] m_a = 0, m_b = 0, m_res = 0;
  logic [3:0] m_op = 0;
  logic       m_gt = 0, m_lt = 0, m_eq = 0;

  always #4 clk = ~clk;

  alu_port_periph u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rd_en(bus_rd_en), .flag_gt(flag_gt), .flag_lt(flag_lt),
    .flag_eq(flag_eq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] addr, input logic [7:0] data);
    @(negedge clk);
    bus_addr = addr; bus_wdata = data; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] addr, output logic [7:0] data,
                          output logic en);
    @(negedge clk);
    bus_addr = addr; bus_rd = 1'b1;
    #1;
    data = bus_rdata; en = bus_rd_en;
    bus_rd = 1'b0;
  endtask

  function automatic string tag(input logic [3:0] op);
    case (op)
      0: return "R4";
      1: return "R5";
      2, 3: return "R6";
      4, 5: return "R7";
      6, 7, 8, 9, 10: return "R8";
      11: return "R9";
      12, 13: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_op(input logic [3:0] op);
    int t;
    m_op = op;
    case (op)
      0: begin t = m_a + m_b + m_gt; m_res = t[7:0]; m_gt = t > 255; end
      1: begin t = m_a - m_b - m_gt; m_res = t[7:0]; m_gt = t < 0; end
      2: begin m_res = {m_a[6:0], m_gt}; m_gt = m_a[7]; end
      3: begin m_res = {m_gt, m_a[7:1]}; m_gt = m_a[0]; end
      4: m_res = {m_a[6:0], m_a[7]};
      5: m_res = {m_a[0], m_a[7:1]};
      6: m_res = m_a | m_b;
      7: m_res = m_a & m_b;
      8: m_res = ~(m_a & m_b);
      9: m_res = m_a ^ m_b;
      10: m_res = ~(m_a ^ m_b);
      11: begin m_gt = m_a > m_b; m_lt = m_a < m_b; m_eq = m_a == m_b; end
      12: begin t = (m_a + 1) % 256; m_res = t[7:0]; m_eq = t == 0; end
      13: begin t = (m_a + 255) % 256; m_res = t[7:0]; m_eq = t == 0; end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op);
    logic [7:0] d;
    logic e;
    bus_write(16'hFFFC, a); m_a = a;
    bus_write(16'hFFFD, b); m_b = b;
    bus_write(16'hFFFE, {4'h0, op});
    model_op(op);
    check({tag(op), " gt"}, flag_gt, m_gt);
    check({tag(op), " lt"}, flag_lt, m_lt);
    check({tag(op), " eq"}, flag_eq, m_eq);
    bus_read(16'hFFFF, d, e);
    check({tag(op), " result"}, d, m_res);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, r0;
    logic e;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(16'hFFFC, d, e); check("R1 A", d, 0);
    bus_read(16'hFFFD, d, e); check("R1 B", d, 0);
    bus_read(16'hFFFE, d, e); check("R1 op", d, 0);
    bus_read(16'hFFFF, d, e); check("R1 result", d, 0);
    check("R1 flags", {flag_gt, flag_lt, flag_eq}, 0);

    // R4 / R9 directed examples
    run_op(8'h01, 8'h05, 4'd0);
    check("R4 1+5", m_res, 8'h06);
    run_op(8'h06, 8'h06, 4'd11);
    check("R9 eq 6==6", flag_eq, 1);

    // R2 decode: readback and unclaimed addresses
    bus_read(16'hFFFE, d, e); check("R2 op readback", d, 11); check("R2 en", e, 1);
    bus_read(16'hFFFB, d, e); check("R2 below base", e, 0);
    bus_read(16'h1234, d, e); check("R2 far addr", e, 0);
    bus_read(16'hFFFF, r0, e);
    bus_write(16'hFFFB, 8'hAA);
    bus_write(16'h7FFE, 8'h00);
    bus_read(16'hFFFC, d, e); check("R2 stray write A", d, 6);
    bus_read(16'hFFFF, d, e); check("R2 stray write result", d, r0);

    // R3 hold across operand writes
    bus_write(16'hFFFC, 8'h99); m_a = 8'h99;
    bus_write(16'hFFFD, 8'h11); m_b = 8'h11;
    bus_read(16'hFFFF, d, e); check("R3 result held", d, r0);
    check("R3 flags held", {flag_gt, flag_lt, flag_eq}, {m_gt, m_lt, m_eq});

    // carry corners
    run_op(8'hFF, 8'h01, 4'd0); check("R4 carry out", flag_gt, 1);
    run_op(8'h01, 8'h01, 4'd0); check("R4 carry in", m_res, 8'h03);
    run_op(8'h00, 8'h01, 4'd1); check("R5 borrow", flag_gt, 1);
    run_op(8'h05, 8'h02, 4'd1); check("R5 borrow in", m_res, 8'h02);
    run_op(8'h80, 8'h00, 4'd2);
    run_op(8'h01, 8'h00, 4'd3);
    run_op(8'h81, 8'h00, 4'd4);
    run_op(8'h81, 8'h00, 4'd5);
    run_op(8'hFF, 8'h00, 4'd12); check("R10 inc wrap", flag_eq, 1);
    run_op(8'h01, 8'h00, 4'd13); check("R10 dec zero", flag_eq, 1);
    run_op(8'h03, 8'h09, 4'd11); check("R9 lt", flag_lt, 1);
    run_op(8'h42, 8'h13, 4'd14);
    run_op(8'h42, 8'h13, 4'd15);

    for (int i = 0; i < 400; i++) begin
      run_op(8'($urandom), 8'($urandom), 4'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule